// File: doc/BRIEF.md
# Accumulator Add Execution Unit

This block carries out the two addition instructions of a small 8-bit accumulator-based core. The first adds an 8-bit constant, taken from the low byte of the instruction word, to the working register W. The second adds W to a data-memory byte and sends the sum either back to W or to that byte. For the memory form, the byte address comes from the bank-select input or from a fixed split access bank. Both instructions update five status flags.

A one-cycle execute strobe, sampled while the unit is idle, captures the 16-bit instruction word. The unit then steps through four phases on four consecutive clock cycles. These are decode, operand read, process and write-back. The data-memory port is synchronous: a read address presented in one cycle returns its data in the next. Fetch, the program counter and every other opcode sit outside the block. A word that matches neither encoding is reported on an unsupported-opcode output and changes nothing.

States and transitions: `ST_IDLE` moves to `ST_DECODE` on the strobe. `ST_DECODE` moves to `ST_READ` for a legal word and back to `ST_IDLE` for an unsupported one. `ST_READ` always moves to `ST_PROCESS`, `ST_PROCESS` always moves to `ST_WRITE`, and `ST_WRITE` always returns to `ST_IDLE`.

Top module: `acc_add_unit`

## Requirements
- R1: A word whose upper byte is 0x0F is the literal add. At the clock edge that ends the write phase, W becomes (W + low byte) mod 256. No data-memory read or write takes place.
- R2: A word whose bits [15:10] are 001001 is the memory add. The data-memory byte at the formed address is read, and W + byte is computed mod 256.
- R3: For the memory add, bit 9 selects the destination. With 0 the sum goes to W and no write occurs. With 1 the sum is written to the same address while `done_o` is high, and W keeps its value.
- R4: Both instructions load `flags_o` = {N, OV, Z, DC, C} (bit 4 down to bit 0) together with the result. C is the carry out of bit 7 and DC the carry out of bit 3. Z is set for a zero result and N copies result bit 7. OV is set when both addends share a sign that the result does not.
- R5: With bit 8 = 0, bits [7:0] below 0x60 address 0x000 to 0x05F, and bits [7:0] of 0x60 and above address 0xF60 to 0xFFF. `bsr_i` is ignored.
- R6: With bit 8 = 1, the 12-bit address is {`bsr_i`, bits [7:0]}.
- R7: A strobe in idle gives the decode, read, process and write phases on the next four cycles. `busy_o` is high throughout, `rf_rd_en_o` is high only in the read phase (memory add only), and `done_o` and `rf_wr_en_o` are high only in the write phase.
- R8: A strobe while `busy_o` is high is ignored. It produces no extra result and does not change the instruction being executed.
- R9: An unsupported word raises `bad_op_o` for exactly one cycle, in the decode phase. It causes no read and no write, W and the flags stay unchanged, and the unit returns to idle on the next cycle.
- R10: After reset W = 0, flags = 0, the unit is idle, and no read or write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe, sampled in idle |
| instr_i | input | 16 | Instruction word |
| bsr_i | input | 4 | Bank-select value |
| rf_rd_en_o | output | 1 | Data-memory read request |
| rf_rd_addr_o | output | 12 | Data-memory read address |
| rf_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| rf_wr_en_o | output | 1 | Data-memory write enable |
| rf_wr_addr_o | output | 12 | Data-memory write address |
| rf_wr_data_o | output | 8 | Data-memory write data |
| w_o | output | 8 | Working register |
| flags_o | output | 5 | {N, OV, Z, DC, C} |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | High in the write phase |
| bad_op_o | output | 1 | Unsupported-opcode pulse |

## Verification
A wrong decode or a wrong bank choice shows on `rf_rd_addr_o` in the read phase, two cycles after the strobe. A bad sum or flag shows on the write port in the write phase, or on `w_o` and `flags_o` one cycle later. A stuck or skipped phase changes the number of cycles until `done_o`, which the bench counts on every instruction. An unsupported word that leaks into W, the flags or memory is caught on the cycle after its `bad_op_o` pulse.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_READ,
        ST_PROCESS,
        ST_WRITE
    } state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LIT,
        OP_REG
    } op_t;

    // bit order on the flags port: {n, ov, z, dc, c}
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    localparam int FLAG_W = 5;

endpackage

// File: rtl/acc_add_decode.sv
module acc_add_decode
    import acc_add_pkg::*;
#(
    parameter int         INSTR_W = 16,
    parameter logic [7:0] LIT_PAT = 8'h0F,
    parameter logic [5:0] REG_PAT = 6'b001001
) (
    input  logic [INSTR_W-1:0] ir,
    output op_t                op,
    output logic               dest_mem,
    output logic               use_bsr,
    output logic [7:0]         field
);
    localparam int TOP = INSTR_W - 1;

    always_comb begin
        op = OP_NONE;
        if (ir[TOP -: 8] == LIT_PAT) begin
            op = OP_LIT;
        end else if (ir[TOP -: 6] == REG_PAT) begin
            op = OP_REG;
        end
    end

    assign dest_mem = ir[9];
    assign use_bsr  = ir[8];
    assign field    = ir[7:0];

endmodule

// File: rtl/acc_add_addr.sv
module acc_add_addr #(
    parameter int                DATA_W    = 8,
    parameter int                BANK_W    = 4,
    parameter logic [DATA_W-1:0] ACC_SPLIT = 8'h60
) (
    input  logic [DATA_W-1:0]        field,
    input  logic                     use_bsr,
    input  logic [BANK_W-1:0]        bsr,
    output logic [BANK_W+DATA_W-1:0] addr
);
    localparam logic [BANK_W-1:0] LOW_BANK  = '0;
    localparam logic [BANK_W-1:0] HIGH_BANK = '1;

    always_comb begin
        if (use_bsr) begin
            addr = {bsr, field};
        end else if (field < ACC_SPLIT) begin
            addr = {LOW_BANK, field};
        end else begin
            addr = {HIGH_BANK, field};
        end
    end

endmodule

// File: rtl/acc_add_alu.sv
module acc_add_alu
    import acc_add_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output flags_t            flg
);
    localparam int NIB = DATA_W / 4;
    localparam int MSB = DATA_W - 1;

    logic [NIB:0] cy;
    assign cy[0] = 1'b0;

    // nibble ripple chain: nibble 0 carry gives the half-carry flag
    for (genvar i = 0; i < NIB; i++) begin : g_nib
        logic [4:0] part;
        assign part            = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, cy[i]};
        assign sum[4*i +: 4]   = part[3:0];
        assign cy[i+1]         = part[4];
    end

    always_comb begin
        flg.c  = cy[NIB];
        flg.dc = cy[1];
        flg.n  = sum[MSB];
        flg.z  = ~|sum;
        flg.ov = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
    import acc_add_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int INSTR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exec_i,
    input  logic [INSTR_W-1:0]       instr_i,
    input  logic [BANK_W-1:0]        bsr_i,
    output logic                     rf_rd_en_o,
    output logic [BANK_W+DATA_W-1:0] rf_rd_addr_o,
    input  logic [DATA_W-1:0]        rf_rd_data_i,
    output logic                     rf_wr_en_o,
    output logic [BANK_W+DATA_W-1:0] rf_wr_addr_o,
    output logic [DATA_W-1:0]        rf_wr_data_o,
    output logic [DATA_W-1:0]        w_o,
    output logic [FLAG_W-1:0]        flags_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     bad_op_o
);
    localparam int ADDR_W = BANK_W + DATA_W;

    state_t              state_q, state_d;
    logic [INSTR_W-1:0]  ir_q;
    logic [DATA_W-1:0]   w_q;
    flags_t              flags_q;
    logic [DATA_W-1:0]   res_q;
    flags_t              res_flg_q;

    op_t                 op;
    logic                dest_mem;
    logic                use_bsr;
    logic [7:0]          field;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   operand;
    logic [DATA_W-1:0]   sum;
    flags_t              sum_flg;

    acc_add_decode #(.INSTR_W(INSTR_W)) u_dec (
        .ir       (ir_q),
        .op       (op),
        .dest_mem (dest_mem),
        .use_bsr  (use_bsr),
        .field    (field)
    );

    acc_add_addr #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_addr (
        .field   (field),
        .use_bsr (use_bsr),
        .bsr     (bsr_i),
        .addr    (addr)
    );

    assign operand = (op == OP_LIT) ? field : rf_rd_data_i;

    acc_add_alu #(.DATA_W(DATA_W)) u_alu (
        .a   (w_q),
        .b   (operand),
        .sum (sum),
        .flg (sum_flg)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (exec_i) state_d = ST_DECODE;
            ST_DECODE:  state_d = (op == OP_NONE) ? ST_IDLE : ST_READ;
            ST_READ:    state_d = ST_PROCESS;
            ST_PROCESS: state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q      <= '0;
            w_q       <= '0;
            flags_q   <= '0;
            res_q     <= '0;
            res_flg_q <= '0;
        end else begin
            if (state_q == ST_IDLE && exec_i) begin
                ir_q <= instr_i;
            end
            if (state_q == ST_PROCESS) begin
                res_q     <= sum;
                res_flg_q <= sum_flg;
            end
            if (state_q == ST_WRITE) begin
                flags_q <= res_flg_q;
                if (op == OP_LIT || (op == OP_REG && !dest_mem)) begin
                    w_q <= res_q;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        done_o     = 1'b0;
        bad_op_o   = 1'b0;
        rf_rd_en_o = 1'b0;
        rf_wr_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_DECODE: begin
                busy_o   = 1'b1;
                bad_op_o = (op == OP_NONE);
            end
            ST_READ: begin
                busy_o     = 1'b1;
                rf_rd_en_o = (op == OP_REG);
            end
            ST_PROCESS: busy_o = 1'b1;
            ST_WRITE: begin
                busy_o     = 1'b1;
                done_o     = 1'b1;
                rf_wr_en_o = (op == OP_REG) && dest_mem;
            end
            default: ;
        endcase
    end

    assign rf_rd_addr_o = addr;
    assign rf_wr_addr_o = addr;
    assign rf_wr_data_o = res_q;
    assign w_o          = w_q;
    assign flags_o      = flags_q;

endmodule

// File: rtl/acc_add_chk.sv
module acc_add_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              bad_op_o,
    input logic              rf_rd_en_o,
    input logic              rf_wr_en_o,
    input logic [DATA_W-1:0] w_o,
    input logic [4:0]        flags_o
);
    a_r7_wr_in_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> done_o);

    a_r7_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en_o |=> (!rf_rd_en_o && busy_o));

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    a_r9_bad_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_o |-> (!rf_rd_en_o && !rf_wr_en_o && !done_o));

    a_r9_bad_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_o |=> (!bad_op_o && !busy_o));

    a_r9_bad_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_o |=> ($stable(w_o) && $stable(flags_o)));

    a_r1_w_only_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> ($stable(w_o) && $stable(flags_o)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rf_rd_en_o && !rf_wr_en_o && !bad_op_o));

endmodule

bind acc_add_unit acc_add_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .bad_op_o   (bad_op_o),
    .rf_rd_en_o (rf_rd_en_o),
    .rf_wr_en_o (rf_wr_en_o),
    .w_o        (w_o),
    .flags_o    (flags_o)
);

// File: tb/tb_acc_add_unit.sv
module tb_acc_add_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [3:0]  bsr_i = '0;
    logic        rf_rd_en_o;
    logic [11:0] rf_rd_addr_o;
    logic [7:0]  rf_rd_data_i;
    logic        rf_wr_en_o;
    logic [11:0] rf_wr_addr_o;
    logic [7:0]  rf_wr_data_o;
    logic [7:0]  w_o;
    logic [4:0]  flags_o;
    logic        busy_o;
    logic        done_o;
    logic        bad_op_o;

    always #2 clk = ~clk;

    acc_add_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .exec_i       (exec_i),
        .instr_i      (instr_i),
        .bsr_i        (bsr_i),
        .rf_rd_en_o   (rf_rd_en_o),
        .rf_rd_addr_o (rf_rd_addr_o),
        .rf_rd_data_i (rf_rd_data_i),
        .rf_wr_en_o   (rf_wr_en_o),
        .rf_wr_addr_o (rf_wr_addr_o),
        .rf_wr_data_o (rf_wr_data_o),
        .w_o          (w_o),
        .flags_o      (flags_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .bad_op_o     (bad_op_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: a fixed pattern until written
    logic [7:0] ram [int];
    logic [7:0] exp_mem [int];
    logic [7:0] rd_q = '0;
    assign rf_rd_data_i = rd_q;

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]};
    endfunction

    always @(posedge clk) begin
        if (rf_rd_en_o) rd_q <= ram.exists(int'(rf_rd_addr_o)) ? ram[int'(rf_rd_addr_o)] : pat(rf_rd_addr_o);
        if (rf_wr_en_o) ram[int'(rf_wr_addr_o)] = rf_wr_data_o;
    end

    typedef struct {
        bit         bad;
        bit         wr;
        logic [11:0] addr;
        logic [7:0] data;
        logic [7:0] w;
        logic [4:0] fl;
    } item_t;

    item_t exp_q [$];
    logic [7:0] mw = '0;
    logic [4:0] mf = '0;

    function automatic logic [15:0] mk_reg(input bit d, input bit a, input logic [7:0] f);
        return {6'b001001, d, a, f};
    endfunction

    // driver: computes expected result, pushes it, drives the strobe
    task automatic issue(input logic [15:0] ins, input bit poke);
        item_t it;
        bit is_lit, is_reg;
        logic [11:0] ad;
        logic [7:0] b;
        logic [8:0] s;
        int n;
        is_lit = (ins[15:8] == 8'h0F);
        is_reg = (ins[15:10] == 6'b001001);
        it.bad = !(is_lit || is_reg);
        it.wr = 1'b0; it.addr = '0; it.data = '0;
        ad = '0;
        if (is_reg) begin
            if (ins[8]) ad = {bsr_i, ins[7:0]};
            else if (ins[7:0] < 8'h60) ad = {4'h0, ins[7:0]};
            else ad = {4'hF, ins[7:0]};
        end
        if (!it.bad) begin
            b = is_lit ? ins[7:0] : (exp_mem.exists(int'(ad)) ? exp_mem[int'(ad)] : pat(ad));
            s = {1'b0, mw} + {1'b0, b};
            mf = {s[7], (mw[7] == b[7]) && (s[7] != mw[7]), s[7:0] == 8'h00,
                  ({1'b0, mw[3:0]} + {1'b0, b[3:0]}) > 5'd15, s[8]};
            if (is_reg && ins[9]) begin
                it.wr = 1'b1; it.addr = ad; it.data = s[7:0];
                exp_mem[int'(ad)] = s[7:0];
            end else begin
                mw = s[7:0];
            end
        end
        it.w = mw; it.fl = mf;
        exp_q.push_back(it);
        @(negedge clk);
        instr_i = ins; exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
        n = 1;
        while (!done_o && !bad_op_o && n < 8) begin
            if (n == 2) begin
                chk(rf_rd_en_o == is_reg, "R7 read enable in read phase", rf_rd_en_o, is_reg);
                if (is_reg) chk(rf_rd_addr_o == ad, ins[8] ? "R6 bank-select address" : "R5 access-bank address",
                                rf_rd_addr_o, ad);
                if (poke) begin instr_i = 16'h0F01; exec_i = 1'b1; end
            end
            if (n == 3) exec_i = 1'b0;
            @(negedge clk);
            n++;
        end
        exec_i = 1'b0;
        if (it.bad) chk(n == 1 && bad_op_o, "R9 bad opcode in decode phase", n, 1);
        else        chk(n == 4 && done_o, "R7 done in fourth cycle", n, 4);
        while (busy_o) @(negedge clk);
        if (poke) begin
            repeat (2) @(negedge clk);
            chk(!busy_o && exp_q.size() == 0, "R8 strobe while busy ignored", busy_o, 0);
        end
    endtask

    // monitor: pops expected items when the design reports a result
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && (done_o || bad_op_o)) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(bad_op_o == it.bad, "R9 opcode legality", bad_op_o, it.bad);
                    if (done_o) begin
                        chk(rf_wr_en_o == it.wr, "R3 write enable", rf_wr_en_o, it.wr);
                        if (it.wr) begin
                            chk(rf_wr_addr_o == it.addr, "R3 write address", rf_wr_addr_o, it.addr);
                            chk(rf_wr_data_o == it.data, "R2 write data", rf_wr_data_o, it.data);
                        end
                    end
                    @(negedge clk);
                    chk(w_o == it.w, "R1 working register", w_o, it.w);
                    chk(flags_o == it.fl, "R4 flags", flags_o, it.fl);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(w_o == 8'h00 && flags_o == 5'h0, "R10 reset W and flags", {w_o, 3'b0, flags_o}, 0);
        chk(!busy_o && !rf_rd_en_o && !rf_wr_en_o, "R10 reset idle", busy_o, 0);
        rst_n = 1'b1;
        // R1 literal adds: 15h then +10h gives 25h
        issue(16'h0F15, 1'b0);
        issue(16'h0F10, 1'b0);
        chk(w_o == 8'h25, "R1 literal example", w_o, 8'h25);
        // carry out of bit 7, W becomes 17h
        issue(16'h0FF2, 1'b0);
        // R2 R3 R6: W=17h plus byte C2h at 0C2h written back as D9h
        bsr_i = 4'h0;
        issue(mk_reg(1'b1, 1'b1, 8'hC2), 1'b0);
        chk(ram[12'h0C2] == 8'hD9 && w_o == 8'h17, "R3 write-back example", ram[12'h0C2], 8'hD9);
        // R5 access bank ignores bsr, boundary around 60h
        bsr_i = 4'h5;
        issue(mk_reg(1'b0, 1'b0, 8'h30), 1'b0);
        issue(mk_reg(1'b0, 1'b0, 8'h5F), 1'b0);
        issue(mk_reg(1'b0, 1'b0, 8'h60), 1'b0);
        issue(mk_reg(1'b0, 1'b0, 8'h80), 1'b0);
        // R6 banked write-back then read of the same byte
        issue(mk_reg(1'b1, 1'b1, 8'h10), 1'b0);
        issue(mk_reg(1'b0, 1'b1, 8'h10), 1'b0);
        // R4 zero result
        issue(16'h0F00 | 16'(8'(9'h100 - {1'b0, mw})), 1'b0);
        chk(w_o == 8'h00 && flags_o[2], "R4 zero flag", flags_o, 5'h07);
        // R4 negative, then signed overflow with carry and half-carry
        issue(16'h0F88, 1'b0);
        issue(16'h0F88, 1'b0);
        // R9 unsupported words
        issue(16'h0E05, 1'b0);
        issue(16'h2800, 1'b0);
        issue(16'hFFFF, 1'b0);
        // R8 strobe during an instruction
        issue(16'h0F21, 1'b1);
        issue(mk_reg(1'b1, 1'b0, 8'hF0), 1'b1);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule